// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

The unit watches the processor's instruction fetch bus. Each fetch is compared against four breakpoint channels. When any enabled channel matches, the unit raises one break exception request. A channel can compare the fetch address exactly. It can also compare it under a bit mask, or join its partner channel to form an inclusive address range.

Software programs the unit through a small register port. There are four 32-bit break address registers, one control register and one per-channel status register. The two even address registers do double duty as mask sources. The enable and range bits decide whether an even register masks its own channel pair or the opposite pair. A hit leaves a sticky flag that software clears by writing a 1 to it.

Register map, selected by `wr_sel` and `rd_sel`:

- 0 to 3: break address registers REG0 to REG3.
- 4: control register. Bits [1:0] are the break type, bits [7:4] are the channel enables (bit 4 is channel 0), bits [9:8] are the range bits for pair 0 and pair 1, and bits [13:12] are the mask enables for pair 0 and pair 1.
- 5: status register. Bits [3:0] are the flags of channels 0 to 3. Any other select reads as zero.

Top module: `ibrk_unit`

## Requirements
- R1: Hits are possible only when the break type field (control bits [1:0]) is 00. With any other value, neither the request nor a flag is ever produced.
- R2: Channels 0 and 2 compare exactly against REG0 and REG2, and only while their enable bit (control bit 4+n) is set. A channel with a clear enable never hits.
- R3: A mask bit of 1 removes that address bit from the comparison. Channel 1 is masked only when mask enable 0 (bit 12) is set, and channel 3 only when mask enable 1 (bit 13) is set. With the mask enable clear, the compare is exact.
- R4: Channel 1 takes its mask from REG0, unless channel 0's enable or range bit 0 is set; it then takes the mask from REG2. Channel 3 takes its mask from REG2, unless channel 2's enable or range bit 1 is set; it then takes the mask from REG0.
- R5: With range bit 0 set and channel 0 or channel 1 enabled, a fetch hits if masked REG0 <= masked address <= masked REG1. The mask is REG2 when mask enable 0 is set, and nothing otherwise. A hit sets flags 0 and 1, and no separate exact compare is made for those two channels.
- R6: With range bit 1 set and channel 2 or channel 3 enabled, a fetch hits if masked REG2 <= masked address <= masked REG3. The mask is REG0 when mask enable 1 is set, and nothing otherwise. A hit sets flags 2 and 3.
- R7: A fetch address is evaluated only while `fetch_valid` is high.
- R8: `brk_req` is high in the cycle after a fetch that hits on any channel, and it is low after any other cycle.
- R9: Flags stay set until software writes 1 to the flag's bit at select 5. A hit in the same cycle as the clear keeps the flag set.
- R10: After reset, all registers and flags read zero and `brk_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 32 | Instruction fetch address |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Read data (combinational) |
| brk_req | output | 1 | Break exception request |

## Verification
A wrong mask route or a wrong range bound shows up on `brk_req` one cycle after the fetch that should or should not have matched. It also shows in the flags read back in that same cycle. A status register that fails to hold a flag, or drops it to a clear in the same cycle as a hit, is seen on the next status read. The random stimulus places break addresses and fetches close together so that both hits and near misses happen. Directed fetches sit exactly on the range bounds and on the edges of the mask.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;
    localparam int ADDR_W = 32;
    localparam int NUM_CH = 4;
    localparam int NUM_PAIR = NUM_CH / 2;
    localparam int SEL_W = 3;
    localparam int SEL_CTRL = 4;
    localparam int SEL_STAT = 5;

    typedef struct packed {
        logic [1:0]          btype;
        logic [NUM_CH-1:0]   en;
        logic [NUM_PAIR-1:0] rng;
        logic [NUM_PAIR-1:0] em;
    } ctrl_t;
endpackage

// File: rtl/ibrk_regs.sv
module ibrk_regs
    import ibrk_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              wr_sel,
    input  logic [ADDR_W-1:0]             wr_data,
    input  logic [SEL_W-1:0]              rd_sel,
    input  logic [NUM_CH-1:0]             hits,
    output logic [ADDR_W-1:0]             rd_data,
    output logic [NUM_CH-1:0][ADDR_W-1:0] bad,
    output ctrl_t                         ctrl,
    output logic                          brk_req
);
    typedef struct packed {
        logic [NUM_CH-1:0][ADDR_W-1:0] bad;
        ctrl_t                         ctrl;
        logic [NUM_CH-1:0]             stat;
        logic                          req;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.req = |hits;
        if (wr_en) begin
            if (int'(wr_sel) < NUM_CH) begin
                s_d.bad[wr_sel[1:0]] = wr_data;
            end else if (int'(wr_sel) == SEL_CTRL) begin
                s_d.ctrl.btype = wr_data[1:0];
                s_d.ctrl.en    = wr_data[7:4];
                s_d.ctrl.rng   = wr_data[9:8];
                s_d.ctrl.em    = wr_data[13:12];
            end else if (int'(wr_sel) == SEL_STAT) begin
                s_d.stat = s_q.stat & ~wr_data[NUM_CH-1:0];
            end
        end
        s_d.stat = s_d.stat | hits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_sel) < NUM_CH) begin
            rd_data = s_q.bad[rd_sel[1:0]];
        end else if (int'(rd_sel) == SEL_CTRL) begin
            rd_data[1:0]   = s_q.ctrl.btype;
            rd_data[7:4]   = s_q.ctrl.en;
            rd_data[9:8]   = s_q.ctrl.rng;
            rd_data[13:12] = s_q.ctrl.em;
        end else if (int'(rd_sel) == SEL_STAT) begin
            rd_data[NUM_CH-1:0] = s_q.stat;
        end
    end

    assign bad     = s_q.bad;
    assign ctrl    = s_q.ctrl;
    assign brk_req = s_q.req;

    // R9: every hit leaves its flag set, even against a clear
    p_hit_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|hits) |=> ((s_q.stat & $past(hits)) == $past(hits)));
    // R9: a flag rises only on a hit
    p_flag_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.stat & ~$past(s_q.stat) & ~$past(hits)) == '0));
    // R8: a hit produces the request one cycle later
    p_req_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|hits) |=> brk_req);
endmodule

// File: rtl/ibrk_pair.sv
module ibrk_pair
    import ibrk_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] even_reg,
    input  logic [ADDR_W-1:0] odd_reg,
    input  logic [ADDR_W-1:0] odd_mask,
    input  logic [ADDR_W-1:0] rng_mask,
    input  logic [1:0]        en,
    input  logic              rng,
    output logic [1:0]        hit
);
    logic [ADDR_W-1:0] a_m, lo_m, hi_m;
    logic              in_rng;

    always_comb begin
        a_m    = addr & ~rng_mask;
        lo_m   = even_reg & ~rng_mask;
        hi_m   = odd_reg & ~rng_mask;
        in_rng = (a_m >= lo_m) && (a_m <= hi_m);
        if (rng) begin
            hit = {2{(|en) && in_rng}};
        end else begin
            hit[0] = en[0] && (addr == even_reg);
            hit[1] = en[1] && ((addr & ~odd_mask) == (odd_reg & ~odd_mask));
        end
    end
endmodule

// File: rtl/ibrk_unit.sv
module ibrk_unit
    import ibrk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [31:0]       fetch_addr,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [2:0]        rd_sel,
    output logic [31:0]       rd_data,
    output logic              brk_req
);
    logic [NUM_CH-1:0][ADDR_W-1:0] bad;
    ctrl_t                         ctrl;
    logic [NUM_CH-1:0]             raw_hit;
    logic [NUM_CH-1:0]             hits;
    logic                          armed;

    assign armed = fetch_valid && (ctrl.btype == 2'b00);
    assign hits  = armed ? raw_hit : '0;

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        localparam int OTHER = NUM_PAIR - 1 - p;
        logic [ADDR_W-1:0] odd_mask, rng_mask;
        logic              swap;

        always_comb begin
            swap     = ctrl.en[2*p] || ctrl.rng[p];
            odd_mask = '0;
            rng_mask = '0;
            if (ctrl.em[p]) begin
                odd_mask = swap ? bad[2*OTHER] : bad[2*p];
                rng_mask = bad[2*OTHER];
            end
        end

        ibrk_pair u_pair (
            .addr     (fetch_addr),
            .even_reg (bad[2*p]),
            .odd_reg  (bad[2*p+1]),
            .odd_mask (odd_mask),
            .rng_mask (rng_mask),
            .en       (ctrl.en[2*p+1:2*p]),
            .rng      (ctrl.rng[p]),
            .hit      (raw_hit[2*p+1:2*p])
        );

        // R5 / R6: a range pair reports a single merged hit
        p_range_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl.rng[p] |-> (hits[2*p] == hits[2*p+1]));
    end

    ibrk_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .hits    (hits),
        .rd_data (rd_data),
        .bad     (bad),
        .ctrl    (ctrl),
        .brk_req (brk_req)
    );

    // R1 / R7: a request needs a valid fetch in instruction-break mode
    p_req_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(fetch_valid && (ctrl.btype == 2'b00)));
    // R2: a disabled pair cannot hit
    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en == '0) |-> (hits == '0));
endmodule

// File: tb/ibrk_unit_tb.sv
module ibrk_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    logic        clk = 0, rst_n = 0;
    logic        fetch_valid = 0, wr_en = 0;
    logic [31:0] fetch_addr = 0, wr_data = 0, rd_data;
    logic [2:0]  wr_sel = 0, rd_sel = 0;
    logic        brk_req;

    int errors = 0, checks = 0, cycles = 0;
    logic [31:0] r[4];
    logic [1:0]  m_type;
    logic [3:0]  m_en, m_sts;
    logic [1:0]  m_rng, m_em;

    ibrk_unit dut_i (.clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .brk_req(brk_req));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic in_rng(input logic [31:0] a, lo, hi, m);
        return ((a & ~m) >= (lo & ~m)) && ((a & ~m) <= (hi & ~m));
    endfunction

    function automatic logic [3:0] expect_hits(input logic [31:0] a);
        logic [3:0] h = 0;
        logic [31:0] m1, m3;
        if (m_type != 2'b00) return 0;
        m1 = m_em[0] ? ((m_en[0] | m_rng[0]) ? r[2] : r[0]) : 0;
        m3 = m_em[1] ? ((m_en[2] | m_rng[1]) ? r[0] : r[2]) : 0;
        if (m_rng[0]) begin
            if ((m_en[0] | m_en[1]) && in_rng(a, r[0], r[1], m_em[0] ? r[2] : 0)) h[1:0] = 2'b11;
        end else begin
            h[0] = m_en[0] && (a == r[0]);
            h[1] = m_en[1] && ((a & ~m1) == (r[1] & ~m1));
        end
        if (m_rng[1]) begin
            if ((m_en[2] | m_en[3]) && in_rng(a, r[2], r[3], m_em[1] ? r[0] : 0)) h[3:2] = 2'b11;
        end else begin
            h[2] = m_en[2] && (a == r[2]);
            h[3] = m_en[3] && ((a & ~m3) == (r[3] & ~m3));
        end
        return h;
    endfunction

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        if (sel < 4) r[sel] = d;
        if (sel == 4) begin m_type = d[1:0]; m_en = d[7:4]; m_rng = d[9:8]; m_em = d[13:12]; end
        if (sel == 5) m_sts = m_sts & ~d[3:0];
    endtask

    task automatic set_ctrl(input logic [1:0] t, input logic [3:0] en, input logic [1:0] rg, input logic [1:0] em);
        wr(3'd4, {18'd0, em, 2'b00, rg, en, 2'b00, t});
    endtask

    // drive one fetch, then check request and flags one cycle later
    task automatic fetch(input logic [31:0] a, input logic v, input logic clr, input string req);
        logic [3:0] h;
        @(negedge clk);
        fetch_valid = v; fetch_addr = a;
        if (clr) begin wr_en = 1; wr_sel = 3'd5; wr_data = 32'hF; end
        h = v ? expect_hits(a) : 4'h0;
        @(negedge clk);
        fetch_valid = 0; wr_en = 0;
        m_sts = (clr ? 4'h0 : m_sts) | h;
        rd_sel = 3'd5;
        #1;
        check({req, " req"}, {31'd0, brk_req}, {31'd0, |h});
        check({req, " flags"}, rd_data, {28'd0, m_sts});
    endtask

    initial begin
        logic [31:0] base;
        void'($urandom(32'd20240611));
        foreach (r[i]) r[i] = 0;
        m_type = 0; m_en = 0; m_rng = 0; m_em = 0; m_sts = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10 reset state
        for (int s = 0; s < 6; s++) begin
            rd_sel = 3'(s); #1;
            check("R10 reset reg", rd_data, 32'd0);
        end
        check("R10 reset req", {31'd0, brk_req}, 32'd0);

        // R3 mask on channel 1 from REG0: 0x12345000..0x12345FFF
        wr(3'd1, 32'h12345678); wr(3'd0, 32'h00000FFF);
        set_ctrl(2'b00, 4'b0010, 2'b00, 2'b01);
        fetch(32'h12345000, 1, 0, "R3 low edge");
        fetch(32'h12345FFF, 1, 0, "R3 high edge");
        fetch(32'h12346000, 1, 0, "R3 outside");
        wr(3'd5, 32'hF);
        set_ctrl(2'b00, 4'b0010, 2'b00, 2'b00);
        fetch(32'h12345ABC, 1, 0, "R3 no mask enable");
        // R7 invalid fetch ignored
        fetch(32'h12345678, 0, 0, "R7 strobe low");
        // R1 other break type
        set_ctrl(2'b01, 4'b1111, 2'b00, 2'b00);
        fetch(32'h12345678, 1, 0, "R1 type 01");
        // R9 sticky flag, then hit wins over clear
        set_ctrl(2'b00, 4'b0010, 2'b00, 2'b00);
        fetch(32'h12345678, 1, 0, "R9 set");
        fetch(32'h00000000, 1, 0, "R9 sticky");
        fetch(32'h12345678, 1, 1, "R9 hit beats clear");
        fetch(32'h00000000, 1, 1, "R9 clear");
        // R5 range 0 with REG2 mask
        wr(3'd0, 32'h12345200); wr(3'd1, 32'h12345300); wr(3'd2, 32'hF0000000);
        set_ctrl(2'b00, 4'b0011, 2'b01, 2'b01);
        fetch(32'h02345200, 1, 1, "R5 masked lower bound");
        fetch(32'hA2345300, 1, 1, "R5 masked upper bound");
        fetch(32'h12345301, 1, 1, "R5 above");
        fetch(32'h123451FF, 1, 1, "R5 below");
        // R6 range 1 without mask
        wr(3'd2, 32'h00001000); wr(3'd3, 32'h00001010);
        set_ctrl(2'b00, 4'b0100, 2'b10, 2'b00);
        fetch(32'h00001010, 1, 1, "R6 upper bound");
        fetch(32'h00001011, 1, 1, "R6 above");
        // R4 swapped mask: channel 3 masked by REG0 while channel 2 enabled
        wr(3'd0, 32'h000000FF); wr(3'd3, 32'h0000AB00);
        set_ctrl(2'b00, 4'b1100, 2'b00, 2'b10);
        fetch(32'h0000ABCD, 1, 1, "R4 swap hit");
        fetch(32'h00001000, 1, 1, "R2 exact ch2");
        fetch(32'h00001001, 1, 1, "R2 exact ch2 miss");

        // random mix
        for (int it = 0; it < 400; it++) begin
            base = $urandom();
            for (int k = 0; k < 4; k++) begin
                logic [31:0] v;
                v = ($urandom_range(0, 3) == 0) ? (32'hFFFFFFFF >> $urandom_range(20, 31))
                                                 : (base ^ ($urandom() & 32'h3FF));
                wr(3'(k), v);
            end
            set_ctrl(($urandom_range(0, 7) == 0) ? 2'($urandom()) : 2'b00,
                     4'($urandom()), 2'($urandom()), 2'($urandom()));
            for (int f = 0; f < 4; f++) begin
                logic [31:0] a;
                a = ($urandom_range(0, 3) == 0) ? r[$urandom_range(0, 3)] : (base ^ ($urandom() & 32'h3FF));
                fetch(a, $urandom_range(0, 5) != 0, $urandom_range(0, 2) == 0, "R2-random");
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule